// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Window

This block gives a host byte-wide access into a paged packet store. The store holds a power-of-two number of pages, each 2048 bytes deep. The host never addresses the store directly. It loads a 16-bit pointer through two byte registers, then reads or writes through a four-byte data window.

The pointer carries two control bits and an 11-bit byte offset:

- **Page source (bit 15).** This bit chooses which page the window reaches: the page at the head of the receive queue, or the page named by the host's packet-number register. Both page numbers arrive as inputs, because queue management lives outside this block.
- **Increment mode (bit 14).** With this bit set, every window access uses the stored offset and then steps it by one. With it clear, the pointer stays put and the window lane is added to the offset for that access.

A read returns data combinationally in the same cycle as the access strobe. A write lands in the store at the clock edge that ends the strobe cycle.

Top module: `pkt_buf_window`

## Requirements
- R1: After reset the pointer is zero, so reads of register offsets 6 and 7 both return 0x00.
- R2: A write to register offset 6 loads pointer bits [7:0] and a write to offset 7 loads pointer bits [15:8]; a read of offset 6 returns pointer bits [7:0].
- R3: A read of register offset 7 returns pointer bits [15:8] with bit 3 of the returned byte (pointer bit 11) forced to zero.
- R4: When pointer bit 15 is 1 the window reaches page `rx_head_page`; when it is 0 the window reaches page `pkt_num`.
- R5: When pointer bit 14 is 0, an access at window offset 8+k (k = 0..3) uses byte address (offset + k) mod 2048, and the pointer is left unchanged.
- R6: When pointer bit 14 is 1, a window access uses the stored offset and then sets pointer bits [10:0] to (offset + 1) mod 2048, keeping bits [15:11].
- R7: A byte written through the window is returned by a later window read of the same page and byte address, and no other byte changes.
- R8: Register offsets other than 6 to 11 are ignored on write (pointer and store unchanged) and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 4 | Register offset of the access |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid in the strobe cycle, zero otherwise |
| rx_head_page | input | PNUM_W | Page number at the head of the receive queue |
| pkt_num | input | PNUM_W | Host-selected packet page number |

## Verification
Every byte of both pages is filled using increment mode from the packet-number source. The whole store is then read back using increment mode from the receive-head source, with the other page presented on `pkt_num`. A crossed page mux or a missed step therefore shows up as a pattern mismatch. A lane sweep in fixed mode, at offsets near the page end, separates a wrapping offset sum from a carry into the page number, and confirms that the pointer stays unchanged. Pointer reads with bit 11 set, and writes to unused offsets, separate the masked high-byte read from a plain one and show that stray registers touch no state.

// File: rtl/pkt_buf_window_pkg.sv
package pkt_buf_window_pkg;

   // Pointer layout
   localparam int PTR_W       = 16;
   localparam int OFS_W       = 11;
   localparam int SEL_BIT     = 15;
   localparam int INC_BIT     = 14;
   localparam int LANE_W      = 2;

   // Register offsets
   localparam logic [3:0] REG_PTR_LO = 4'd6;
   localparam logic [3:0] REG_PTR_HI = 4'd7;
   localparam logic [3:0] REG_WIN_LO = 4'd8;
   localparam logic [3:0] REG_WIN_HI = 4'd11;

   localparam logic [7:0] HI_READ_MASK = 8'hF7;

   typedef enum logic [1:0] {
      KIND_OTHER  = 2'd0,
      KIND_PTR_LO = 2'd1,
      KIND_PTR_HI = 2'd2,
      KIND_DATA   = 2'd3
   } acc_kind_t;

   function automatic acc_kind_t decode_reg(input logic [3:0] r);
      if (r == REG_PTR_LO)                        return KIND_PTR_LO;
      else if (r == REG_PTR_HI)                   return KIND_PTR_HI;
      else if (r >= REG_WIN_LO && r <= REG_WIN_HI) return KIND_DATA;
      else                                        return KIND_OTHER;
   endfunction

endpackage

// File: rtl/pbw_ptr_reg.sv
module pbw_ptr_reg
   import pkt_buf_window_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             win_acc,
   output logic [PTR_W-1:0] ptr_q
);

   logic [PTR_W-1:0] ptr_d;
   logic [OFS_W-1:0] ofs_step;

   assign ofs_step = ptr_q[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};

   always_comb begin
      ptr_d = ptr_q;
      if (wr_lo)
         ptr_d[7:0] = wdata;
      if (wr_hi)
         ptr_d[15:8] = wdata;
      if (win_acc && ptr_q[INC_BIT])
         ptr_d[OFS_W-1:0] = ofs_step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else
         ptr_q <= ptr_d;
   end

   assert_keep_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && ptr_q[INC_BIT]) |=>
         (ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W])));

   assert_step_ofs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && ptr_q[INC_BIT]) |=>
         (ptr_q[OFS_W-1:0] == OFS_W'($past(ptr_q[OFS_W-1:0]) + OFS_W'(1))));

   assert_hold_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && !ptr_q[INC_BIT]) |=> $stable(ptr_q));

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_acc && !wr_lo && !wr_hi) |=> $stable(ptr_q));

endmodule

// File: rtl/pbw_addr_gen.sv
module pbw_addr_gen
   import pkt_buf_window_pkg::*;
#(
   parameter int PNUM_W = 2,
   parameter int PG_W   = 1,
   localparam int ADDR_W = PG_W + OFS_W
)(
   input  logic [PTR_W-1:0]  ptr_q,
   input  logic [LANE_W-1:0] lane,
   input  logic [PNUM_W-1:0] rx_page,
   input  logic [PNUM_W-1:0] pkt_page,
   output logic [ADDR_W-1:0] mem_addr
);

   logic [PNUM_W-1:0] page_sel;
   logic [OFS_W-1:0]  ofs_eff;

   always_comb begin
      page_sel = ptr_q[SEL_BIT] ? rx_page : pkt_page;
      if (ptr_q[INC_BIT])
         ofs_eff = ptr_q[OFS_W-1:0];
      else
         ofs_eff = ptr_q[OFS_W-1:0] + {{(OFS_W-LANE_W){1'b0}}, lane};
      mem_addr = {page_sel[PG_W-1:0], ofs_eff};
   end

endmodule

// File: rtl/pbw_byte_mem.sv
module pbw_byte_mem #(
   parameter int ADDR_W = 12,
   localparam int DEPTH = 1 << ADDR_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         store[addr] <= wdata;
   end

   assign rdata = store[addr];

endmodule

// File: rtl/pkt_buf_window.sv
module pkt_buf_window
   import pkt_buf_window_pkg::*;
#(
   parameter int PAGE_COUNT = 2,
   parameter int PNUM_W     = 2,
   parameter bit ZERO_IDLE  = 1'b1,
   localparam int PG_W   = $clog2(PAGE_COUNT),
   localparam int ADDR_W = PG_W + OFS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [3:0]        acc_reg,
   input  logic [7:0]        acc_wdata,
   output logic [7:0]        acc_rdata,
   input  logic [PNUM_W-1:0] rx_head_page,
   input  logic [PNUM_W-1:0] pkt_num
);

   generate
      if (PAGE_COUNT < 2 || (PAGE_COUNT & (PAGE_COUNT - 1)) != 0) begin : g_bad_pages
         $error("PAGE_COUNT must be a power of two and at least 2");
      end
      if (PNUM_W < PG_W) begin : g_bad_pnum
         $error("PNUM_W too narrow for PAGE_COUNT");
      end
   endgenerate

   acc_kind_t         kind;
   logic              win_acc;
   logic              wr_lo;
   logic              wr_hi;
   logic              mem_we;
   logic [PTR_W-1:0]  ptr_q;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_rd;
   logic [7:0]        rd_mux;

   assign kind    = decode_reg(acc_reg);
   assign win_acc = acc_en && (kind == KIND_DATA);
   assign wr_lo   = acc_en && acc_wr && (kind == KIND_PTR_LO);
   assign wr_hi   = acc_en && acc_wr && (kind == KIND_PTR_HI);
   assign mem_we  = win_acc && acc_wr;

   pbw_ptr_reg u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (acc_wdata),
      .win_acc (win_acc),
      .ptr_q   (ptr_q)
   );

   pbw_addr_gen #(
      .PNUM_W (PNUM_W),
      .PG_W   (PG_W)
   ) u_addr (
      .ptr_q    (ptr_q),
      .lane     (acc_reg[LANE_W-1:0]),
      .rx_page  (rx_head_page),
      .pkt_page (pkt_num),
      .mem_addr (mem_addr)
   );

   pbw_byte_mem #(
      .ADDR_W (ADDR_W)
   ) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (acc_wdata),
      .rdata (mem_rd)
   );

   always_comb begin
      case (kind)
         KIND_PTR_LO: rd_mux = ptr_q[7:0];
         KIND_PTR_HI: rd_mux = ptr_q[15:8] & HI_READ_MASK;
         KIND_DATA:   rd_mux = mem_rd;
         default:     rd_mux = 8'h00;
      endcase
   end

   generate
      if (ZERO_IDLE) begin : g_rd_gated
         assign acc_rdata = (acc_en && !acc_wr) ? rd_mux : 8'h00;
      end else begin : g_rd_open
         assign acc_rdata = rd_mux;
      end
   endgenerate

   assert_hide_bit11_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && kind == KIND_PTR_HI) |-> (acc_rdata[3] == 1'b0));

   assert_other_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && kind == KIND_OTHER) |-> (acc_rdata == 8'h00));

endmodule

// File: tb/tb_pkt_buf_window.sv
module tb_pkt_buf_window;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic       acc_wr = 1'b0;
   logic [3:0] acc_reg = 4'd0;
   logic [7:0] acc_wdata = 8'd0;
   logic [7:0] acc_rdata;
   logic [1:0] rx_head_page = 2'd0;
   logic [1:0] pkt_num = 2'd0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pkt_buf_window dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_en       (acc_en),
      .acc_wr       (acc_wr),
      .acc_reg      (acc_reg),
      .acc_wdata    (acc_wdata),
      .acc_rdata    (acc_rdata),
      .rx_head_page (rx_head_page),
      .pkt_num      (pkt_num)
   );

   function automatic logic [7:0] pat(input int p, input int a);
      return 8'((a * 7) + (p * 91) + (a >> 8));
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic acc(input bit wr, input logic [3:0] r, input logic [7:0] d,
                      output logic [7:0] q);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_reg = r; acc_wdata = d;
      #2 q = acc_rdata;
      @(posedge clk);
      #1 acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic set_ptr(input logic [15:0] v);
      logic [7:0] q;
      acc(1'b1, 4'd6, v[7:0], q);
      acc(1'b1, 4'd7, v[15:8], q);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] q;
      int offs [5] = '{0, 'h123, 'h7FC, 'h7FD, 'h7FF};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      acc(1'b0, 4'd6, 8'h00, q); chk("R1 ptr lo", q, 8'h00);
      acc(1'b0, 4'd7, 8'h00, q); chk("R1 ptr hi", q, 8'h00);

      // R2 / R3 pointer bytes
      set_ptr(16'hFF34);
      acc(1'b0, 4'd6, 8'h00, q); chk("R2 ptr lo", q, 8'h34);
      acc(1'b0, 4'd7, 8'h00, q); chk("R3 ptr hi masked", q, 8'hF7);
      set_ptr(16'h0800);
      acc(1'b0, 4'd7, 8'h00, q); chk("R3 bit11 hidden", q, 8'h00);

      // R8 unused offsets
      set_ptr(16'h4155);
      acc(1'b1, 4'd3, 8'hAA, q);
      acc(1'b1, 4'd12, 8'h0F, q);
      acc(1'b1, 4'd0, 8'h99, q);
      acc(1'b0, 4'd6, 8'h00, q); chk("R8 ptr lo kept", q, 8'h55);
      acc(1'b0, 4'd7, 8'h00, q); chk("R8 ptr hi kept", q, 8'h41);
      acc(1'b0, 4'd12, 8'h00, q); chk("R8 read zero", q, 8'h00);
      acc(1'b0, 4'd15, 8'h00, q); chk("R8 read zero", q, 8'h00);

      // R6 fill both pages by packet-number source with increment
      for (int p = 0; p < 2; p++) begin
         pkt_num = 2'(p); rx_head_page = 2'(1 - p);
         set_ptr(16'h4000);
         for (int a = 0; a < 2048; a++)
            acc(1'b1, 4'(8 + (a % 4)), pat(p, a), q);
         acc(1'b0, 4'd6, 8'h00, q); chk("R6 wrap lo", q, 8'h00);
         acc(1'b0, 4'd7, 8'h00, q); chk("R6 upper kept", q, 8'h40);
      end

      // R4 R6 R7 read back through receive-head source
      for (int p = 0; p < 2; p++) begin
         rx_head_page = 2'(p); pkt_num = 2'(1 - p);
         set_ptr(16'hC000);
         for (int a = 0; a < 2048; a++) begin
            acc(1'b0, 4'(8 + ((a * 3) % 4)), 8'h00, q);
            chk("R4 R6 R7 readback", q, pat(p, a));
         end
      end

      // R5 fixed-mode lane sweep near page end, bit 11 set
      for (int p = 0; p < 2; p++) begin
         pkt_num = 2'(p); rx_head_page = 2'(1 - p);
         foreach (offs[i]) begin
            set_ptr(16'h0800 | 16'(offs[i]));
            for (int l = 0; l < 4; l++) begin
               acc(1'b0, 4'(8 + l), 8'h00, q);
               chk("R5 lane addr", q, pat(p, (offs[i] + l) % 2048));
            end
            acc(1'b0, 4'd6, 8'h00, q); chk("R5 ptr lo held", q, 8'(offs[i]));
            acc(1'b0, 4'd7, 8'h00, q); chk("R5 ptr hi held", q, 8'((offs[i] >> 8) & 7));
         end
      end

      // R5 R7 fixed-mode lane write with wrap, receive-head source
      rx_head_page = 2'd1; pkt_num = 2'd0;
      set_ptr(16'h87FF);
      acc(1'b1, 4'd10, 8'h5A, q);
      pkt_num = 2'd1; rx_head_page = 2'd0;
      set_ptr(16'h0001);
      acc(1'b0, 4'd8, 8'h00, q); chk("R7 written byte", q, 8'h5A);
      acc(1'b0, 4'd9, 8'h00, q); chk("R7 neighbour kept", q, pat(1, 2));
      set_ptr(16'h0000);
      acc(1'b0, 4'd8, 8'h00, q); chk("R7 neighbour kept", q, pat(1, 0));
      set_ptr(16'h8001);
      acc(1'b0, 4'd8, 8'h00, q); chk("R4 other page kept", q, pat(0, 1));

      finish_run();
   end

endmodule